// File: doc/BRIEF.md
# Two-Context Miss-Driven Fetch Switcher

This block steers instruction fetch for a five-stage in-order pipeline that holds two hardware thread contexts. It keeps one program counter and one scheduling state per context. Each cycle it names the context that fetches, together with that context's PC and its register-bank tag. When a long-latency cache miss is reported, fetch moves to the other context instead of stalling for the whole memory latency, so the pipeline loses only about one slot per miss.

An instruction-cache miss is reported against the fetch of the current cycle. The missing fetch is discarded, and its PC is kept as the restart point. A data-cache miss is reported from the memory stage with the thread tag and PC of the missing instruction. The younger instructions of that thread in fetch, decode and execute are discarded, and the thread later restarts at the missing instruction itself. A context becomes eligible again when a completion pulse tagged with its thread number arrives. If no context is eligible, fetch issues bubbles.

The pipeline applies the kill outputs only to instructions whose thread tag matches the kill tag. Instructions in writeback always complete. Branch redirects carry a thread tag and change only that thread's PC.

Top module: `mt_fetch_ctrl`

## Requirements
- R1: While reset is held, and until the synchronised reset releases, fetch_valid_o is 1, fetch_tid_o is 0, fetch_pc_o is RST_PC0 (default 0x100) and regbank_o is 0. Thread 1 waits to run at RST_PC1 (default 0x800).
- R2: In a cycle with fetch_valid_o high and no miss or redirect for the fetching thread, that thread's PC rises by INC (default 4) at the next cycle.
- R3: An instruction miss (icache_miss_i high while fetch_valid_o is 1) drives kill_if_o=1, kill_id_o=0, kill_ex_o=0 and kill_tid_o equal to the fetching thread in that cycle. If the other thread is eligible, it fetches in the next cycle.
- R4: A thread that took an instruction miss resumes fetch at the PC of the fetch that missed.
- R5: A data miss (dcache_miss_i with tag dcache_miss_tid_i and PC dcache_miss_pc_i) drives kill_if_o, kill_id_o and kill_ex_o high with kill_tid_o equal to the tag in that cycle. The thread later resumes at dcache_miss_pc_i, and fetch moves to the other thread when it is eligible.
- R6: A completion pulse (miss_done_i with tag miss_done_tid_i) makes only the tagged thread eligible, and only if that thread is waiting. A pulse for a running or already eligible thread has no effect.
- R7: If the other thread is not eligible when the fetching thread misses, fetch_valid_o stays 0 from the next cycle on. A completion pulse in cycle d then restores fetch in cycle d+2, for the tagged thread.
- R8: regbank_o always equals fetch_tid_o.
- R9: A redirect (redirect_i, tag redirect_tid_i, target redirect_pc_i) loads the target into the tagged thread's PC only. A redirect for the fetching thread makes the next fetch use the target, and a redirect for the other thread leaves the fetching thread's sequence unchanged.
- R10: When a data miss and an instruction miss hit the same thread in the same cycle, the data miss decides: kill_id_o is 1, and the thread resumes at dcache_miss_pc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| icache_miss_i | input | 1 | The current fetch missed in the instruction cache |
| dcache_miss_i | input | 1 | The instruction in the memory stage missed in the data cache |
| dcache_miss_tid_i | input | 1 | Thread tag of the missing memory-stage instruction |
| dcache_miss_pc_i | input | PC_W | PC of the missing memory-stage instruction |
| miss_done_i | input | 1 | An outstanding miss has been filled |
| miss_done_tid_i | input | 1 | Thread tag of the filled miss |
| redirect_i | input | 1 | Taken-branch redirect |
| redirect_tid_i | input | 1 | Thread tag of the redirect |
| redirect_pc_i | input | PC_W | Redirect target |
| fetch_valid_o | output | 1 | A fetch is issued this cycle (0 = bubble) |
| fetch_pc_o | output | PC_W | Fetch address |
| fetch_tid_o | output | 1 | Thread tag of the fetch |
| regbank_o | output | 1 | Register-bank and address-map select tag for the fetch |
| kill_if_o | output | 1 | Discard the fetch-stage instruction of thread kill_tid_o |
| kill_id_o | output | 1 | Discard the decode-stage instruction of thread kill_tid_o |
| kill_ex_o | output | 1 | Discard the execute-stage instruction of thread kill_tid_o |
| kill_tid_o | output | 1 | Thread the kill outputs apply to |

## Verification
The bench sweeps the length of the run between instruction misses. A design that advances the PC on the missing fetch would resume one word late, and one that saved the wrong context would resume at the other thread's address. Data misses check that the restart PC is the memory-stage PC and not the fetch PC, and that decode and execute are killed for an instruction miss only when a data miss coincides with it. The stall case checks that bubbles are issued and that a completion pulse revives only the thread it is tagged with, two cycles later. A design that let a pulse wake a running thread, or applied a redirect to the wrong context, would fetch from the wrong address.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
  typedef enum logic [1:0] {
    TS_RUN  = 2'd0,
    TS_RDY  = 2'd1,
    TS_WAIT = 2'd2
  } tstate_e;
endpackage

// File: rtl/mtf_rst_sync.sv
module mtf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/mtf_thread_ctx.sv
module mtf_thread_ctx
  import mtf_pkg::*;
#(
  parameter int          PC_W    = 32,
  parameter int          INC     = 4,
  parameter logic [31:0] RST_PC  = 32'h0,
  parameter bit          RST_RUN = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance_i,
  input  logic            dmiss_i,
  input  logic [PC_W-1:0] dmiss_pc_i,
  input  logic            redir_i,
  input  logic [PC_W-1:0] redir_pc_i,
  input  logic            go_wait_i,
  input  logic            go_run_i,
  input  logic            done_i,
  output logic [PC_W-1:0] pc_o,
  output tstate_e         state_o
);
  localparam logic [PC_W-1:0] STEP     = PC_W'(INC);
  localparam logic [PC_W-1:0] PC_INIT  = RST_PC[PC_W-1:0];
  localparam tstate_e         ST_INIT  = RST_RUN ? TS_RUN : TS_RDY;

  logic [PC_W-1:0] pc_q, pc_n;
  tstate_e         st_q, st_n;
  logic            pc_en, st_en;

  // PC source priority: data-miss restart, then redirect, then sequential step
  always_comb begin
    pc_n  = pc_q;
    pc_en = 1'b0;
    if (dmiss_i) begin
      pc_n  = dmiss_pc_i;
      pc_en = 1'b1;
    end else if (redir_i) begin
      pc_n  = redir_pc_i;
      pc_en = 1'b1;
    end else if (advance_i) begin
      pc_n  = pc_q + STEP;
      pc_en = 1'b1;
    end
  end

  always_comb begin
    st_n  = st_q;
    st_en = 1'b0;
    if (go_wait_i) begin
      st_n  = TS_WAIT;
      st_en = 1'b1;
    end else if (go_run_i) begin
      st_n  = TS_RUN;
      st_en = 1'b1;
    end else if (done_i && st_q == TS_WAIT) begin
      st_n  = TS_RDY;
      st_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= PC_INIT;
      st_q <= ST_INIT;
    end else begin
      if (pc_en) pc_q <= pc_n;
      if (st_en) st_q <= st_n;
    end
  end

  assign pc_o    = pc_q;
  assign state_o = st_q;

  assert_dmiss_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dmiss_i |=> pc_q == $past(dmiss_pc_i));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !dmiss_i && !redir_i) |=> pc_q == $past(pc_q) + STEP);

  assert_done_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && st_q == TS_WAIT && !go_wait_i && !go_run_i) |=> st_q == TS_RDY);

  assert_miss_parks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go_wait_i |=> st_q == TS_WAIT);
endmodule

// File: rtl/mtf_sched.sv
module mtf_sched (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ready_i,
  input  logic       leave_i,
  output logic       cur_o,
  output logic       active_o,
  output logic [1:0] grant_o
);
  logic cur_q, cur_n, act_q, act_n;
  logic alt;

  assign alt = ~cur_q;

  always_comb begin
    cur_n   = cur_q;
    act_n   = act_q;
    grant_o = 2'b00;
    if (act_q) begin
      if (leave_i) begin
        if (ready_i[alt]) begin
          grant_o[alt] = 1'b1;
          cur_n        = alt;
        end else begin
          act_n = 1'b0;
        end
      end
    end else begin
      // idle: favour the thread that did not miss last
      if (ready_i[alt]) begin
        grant_o[alt] = 1'b1;
        cur_n        = alt;
        act_n        = 1'b1;
      end else if (ready_i[cur_q]) begin
        grant_o[cur_q] = 1'b1;
        act_n          = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= 1'b0;
      act_q <= 1'b1;
    end else begin
      cur_q <= cur_n;
      act_q <= act_n;
    end
  end

  assign cur_o    = cur_q;
  assign active_o = act_q;

  assert_switch_away_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && leave_i) |=> (!act_q || cur_q != $past(cur_q)));

  assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_idle_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && ready_i == 2'b00) |=> !act_q);
endmodule

// File: rtl/mt_fetch_ctrl.sv
module mt_fetch_ctrl
  import mtf_pkg::*;
#(
  parameter int          PC_W    = 32,
  parameter int          INC     = 4,
  parameter logic [31:0] RST_PC0 = 32'h0000_0100,
  parameter logic [31:0] RST_PC1 = 32'h0000_0800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            icache_miss_i,
  input  logic            dcache_miss_i,
  input  logic            dcache_miss_tid_i,
  input  logic [PC_W-1:0] dcache_miss_pc_i,
  input  logic            miss_done_i,
  input  logic            miss_done_tid_i,
  input  logic            redirect_i,
  input  logic            redirect_tid_i,
  input  logic [PC_W-1:0] redirect_pc_i,
  output logic            fetch_valid_o,
  output logic [PC_W-1:0] fetch_pc_o,
  output logic            fetch_tid_o,
  output logic            regbank_o,
  output logic            kill_if_o,
  output logic            kill_id_o,
  output logic            kill_ex_o,
  output logic            kill_tid_o
);
  localparam int NTHR = 2;

  logic            rst_sync_n;
  logic            cur, active, leave, imiss_eff;
  logic [1:0]      grant, ready;
  logic [PC_W-1:0] pc   [NTHR];
  tstate_e         st   [NTHR];

  mtf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign imiss_eff = icache_miss_i & active;
  assign leave     = active & (icache_miss_i | (dcache_miss_i & (dcache_miss_tid_i == cur)));

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic dm_here, im_here, rd_here, is_cur;
    assign is_cur  = active & (cur == t[0]);
    assign dm_here = dcache_miss_i & (dcache_miss_tid_i == t[0]);
    assign im_here = imiss_eff & (cur == t[0]) & ~dm_here;
    assign rd_here = redirect_i & (redirect_tid_i == t[0]);
    assign ready[t] = (st[t] == TS_RDY);

    mtf_thread_ctx #(
      .PC_W    (PC_W),
      .INC     (INC),
      .RST_PC  ((t == 0) ? RST_PC0 : RST_PC1),
      .RST_RUN (t == 0)
    ) u_ctx (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .advance_i  (is_cur & ~leave),
      .dmiss_i    (dm_here),
      .dmiss_pc_i (dcache_miss_pc_i),
      .redir_i    (rd_here),
      .redir_pc_i (redirect_pc_i),
      .go_wait_i  (dm_here | im_here),
      .go_run_i   (grant[t]),
      .done_i     (miss_done_i & (miss_done_tid_i == t[0])),
      .pc_o       (pc[t]),
      .state_o    (st[t])
    );
  end

  mtf_sched u_sched (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ready_i  (ready),
    .leave_i  (leave),
    .cur_o    (cur),
    .active_o (active),
    .grant_o  (grant)
  );

  assign fetch_valid_o = active;
  assign fetch_pc_o    = pc[cur];
  assign fetch_tid_o   = cur;
  assign regbank_o     = cur;
  assign kill_if_o     = imiss_eff | dcache_miss_i;
  assign kill_id_o     = dcache_miss_i;
  assign kill_ex_o     = dcache_miss_i;
  assign kill_tid_o    = dcache_miss_i ? dcache_miss_tid_i : cur;

  assert_fetch_owner_runs_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_valid_o |-> st[fetch_tid_o] == TS_RUN);

  assert_one_runner_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({st[0] == TS_RUN, st[1] == TS_RUN}) <= 1);

  assert_deep_kill_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    kill_id_o |-> (kill_if_o && kill_ex_o));
endmodule

// File: tb/test_mt_fetch_ctrl.sv
module test_mt_fetch_ctrl;
  localparam int CLK_P = 10;
  localparam int PC_W  = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic icache_miss_i, dcache_miss_i, dcache_miss_tid_i;
  logic [PC_W-1:0] dcache_miss_pc_i;
  logic miss_done_i, miss_done_tid_i;
  logic redirect_i, redirect_tid_i;
  logic [PC_W-1:0] redirect_pc_i;
  logic fetch_valid_o, fetch_tid_o, regbank_o;
  logic [PC_W-1:0] fetch_pc_o;
  logic kill_if_o, kill_id_o, kill_ex_o, kill_tid_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] epc [2];
  int cur;
  logic [31:0] saved;

  always #(CLK_P/2) clk = ~clk;

  mt_fetch_ctrl i_mt_fetch_ctrl (
    .clk(clk), .rst_n(rst_n),
    .icache_miss_i(icache_miss_i), .dcache_miss_i(dcache_miss_i),
    .dcache_miss_tid_i(dcache_miss_tid_i), .dcache_miss_pc_i(dcache_miss_pc_i),
    .miss_done_i(miss_done_i), .miss_done_tid_i(miss_done_tid_i),
    .redirect_i(redirect_i), .redirect_tid_i(redirect_tid_i), .redirect_pc_i(redirect_pc_i),
    .fetch_valid_o(fetch_valid_o), .fetch_pc_o(fetch_pc_o), .fetch_tid_o(fetch_tid_o),
    .regbank_o(regbank_o), .kill_if_o(kill_if_o), .kill_id_o(kill_id_o),
    .kill_ex_o(kill_ex_o), .kill_tid_o(kill_tid_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    icache_miss_i = 0; dcache_miss_i = 0; dcache_miss_tid_i = 0; dcache_miss_pc_i = '0;
    miss_done_i = 0; miss_done_tid_i = 0;
    redirect_i = 0; redirect_tid_i = 0; redirect_pc_i = '0;
  endtask

  task automatic expect_fetch(string req);
    chk(req, "valid", fetch_valid_o, 1);
    chk(req, "tid", fetch_tid_o, cur);
    chk(req, "pc", fetch_pc_o, epc[cur]);
    chk("R8", "bank", regbank_o, fetch_tid_o);
  endtask

  // n plain cycles; optional completion pulse for thread done_tid in the first
  task automatic run_cycles(int n, int done_tid);
    for (int i = 0; i < n; i++) begin
      if (i == 0 && done_tid >= 0) begin
        miss_done_i = 1; miss_done_tid_i = done_tid[0];
      end
      #1 expect_fetch(done_tid == cur ? "R6" : "R2");
      @(negedge clk); clr();
      epc[cur] = epc[cur] + 4;
    end
  endtask

  task automatic imiss_switch(bit other_ready);
    icache_miss_i = 1;
    #1;
    chk("R3", "kill_if", kill_if_o, 1);
    chk("R3", "kill_id", kill_id_o, 0);
    chk("R3", "kill_ex", kill_ex_o, 0);
    chk("R3", "kill_tid", kill_tid_o, cur);
    @(negedge clk); clr();
    #1;
    if (other_ready) begin
      cur = 1 - cur;
      expect_fetch("R4");
    end else begin
      chk("R7", "bubble", fetch_valid_o, 0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "valid", fetch_valid_o, 1);
    chk("R1", "tid", fetch_tid_o, 0);
    chk("R1", "pc", fetch_pc_o, 32'h100);
    chk("R1", "bank", regbank_o, 0);
    @(negedge clk); @(negedge clk);
    #1 chk("R1", "pc held", fetch_pc_o, 32'h100);
    epc[0] = 32'h100; epc[1] = 32'h800; cur = 0;

    // sweep of run lengths between instruction misses
    for (int r = 0; r < 8; r++) begin
      run_cycles(r + 1, 1 - cur);
      imiss_switch(1);
    end

    // R7: other thread waiting -> bubbles until a tagged completion
    run_cycles(2, -1);
    imiss_switch(0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1 chk("R7", "idle", fetch_valid_o, 0);
    end
    miss_done_i = 1; miss_done_tid_i = cur[0];
    #1 chk("R7", "idle at pulse", fetch_valid_o, 0);
    @(negedge clk); clr();
    #1 chk("R7", "idle after pulse", fetch_valid_o, 0);
    @(negedge clk);
    #1 expect_fetch("R6");

    // R5: data miss
    run_cycles(3, 1 - cur);
    saved = epc[cur] - 12;
    dcache_miss_i = 1; dcache_miss_tid_i = cur[0]; dcache_miss_pc_i = saved;
    #1;
    chk("R5", "kill_if", kill_if_o, 1);
    chk("R5", "kill_id", kill_id_o, 1);
    chk("R5", "kill_ex", kill_ex_o, 1);
    chk("R5", "kill_tid", kill_tid_o, cur);
    @(negedge clk); clr();
    epc[cur] = saved; cur = 1 - cur;
    #1 expect_fetch("R5");
    run_cycles(2, 1 - cur);
    imiss_switch(1);
    chk("R5", "restart pc", fetch_pc_o, saved);

    // R9: redirects
    redirect_i = 1; redirect_tid_i = ~cur[0]; redirect_pc_i = 32'h2000;
    #1 expect_fetch("R9");
    @(negedge clk); clr();
    epc[cur] = epc[cur] + 4; epc[1 - cur] = 32'h2000;
    #1 expect_fetch("R9");
    run_cycles(1, 1 - cur);
    redirect_i = 1; redirect_tid_i = cur[0]; redirect_pc_i = 32'h3000;
    @(negedge clk); clr();
    epc[cur] = 32'h3000;
    #1 expect_fetch("R9");
    run_cycles(1, -1);
    imiss_switch(1);
    chk("R9", "other target", fetch_pc_o, 32'h2000);

    // R10: coincident data and instruction miss on the same thread
    run_cycles(2, 1 - cur);
    dcache_miss_i = 1; dcache_miss_tid_i = cur[0]; dcache_miss_pc_i = 32'h4444;
    icache_miss_i = 1;
    #1 chk("R10", "kill_id", kill_id_o, 1);
    @(negedge clk); clr();
    epc[cur] = 32'h4444; cur = 1 - cur;
    #1 expect_fetch("R10");
    run_cycles(2, 1 - cur);
    imiss_switch(1);
    chk("R10", "restart pc", fetch_pc_o, 32'h4444);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule